// File: doc/BRIEF.md
# Coprocessor Memory Access Guard

This block sits on the host side of a vector coprocessor and filters every host access to the coprocessor's local RAM and register file. While the coprocessor's command-list engine is idle, the guard forwards host reads and writes to the memory side unchanged. While the engine is busy, it rejects any host access that falls outside a small page of control registers. A rejected read returns a fixed poison word. A rejected write never reaches memory. A rejected access of either kind latches an error flag and raises a one-cycle non-maskable interrupt. It also sends a one-cycle abort to the engine, which stops the running command list even when a command is only partly done.

The host port takes one request per cycle and answers each request exactly one cycle later. The memory side has a one-cycle read latency. The control page is the top `CTRL_WORDS` word addresses of the window. Accesses to this page are never rejected, so the host can always reach the engine's control, mask, flag and abort registers. One word of this page is the guard's own status register, which holds the error flag.

Top module: `cop_access_guard`

## Requirements
- R1: With `eng_busy` low, a host write at any address outside the status word is forwarded to the memory side in the same cycle, and a later read returns the stored word. No `nmi` or `eng_abort` results.
- R2: With `eng_busy` high, a host read at an address below the control page (the control page is `h_addr[AW-1:CW]` all ones, where CW = log2(CTRL_WORDS)) returns `POISON` (default 32'hBAD0BAD0). The read is not forwarded to memory.
- R3: With `eng_busy` high, a host write below the control page is not forwarded, so memory contents are unchanged when read back later.
- R4: With `eng_busy` high, reads and writes inside the control page are forwarded or served normally, and they raise no `nmi` or `eng_abort`.
- R5: A rejected access sets the error flag, which is bit 0 of the status word at control-page index `STAT_IDX` (default address 1021). The flag reads as 1 from the next cycle on.
- R6: The error flag clears only when the host writes the status word with bit 0 = 1. A write with bit 0 = 0 leaves the flag set.
- R7: `nmi` is high for exactly one cycle, in the cycle after each rejected access.
- R8: `eng_abort` is high for exactly one cycle, in the same cycle as the `nmi` pulse.
- R9: `h_rvalid` is high in the cycle after each host request and low otherwise.
- R10: After reset, `h_rvalid`, `nmi`, `eng_abort` and the error flag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_req | input | 1 | Host request valid |
| h_we | input | 1 | Host write enable |
| h_addr | input | AW | Host word address |
| h_wdata | input | DW | Host write data |
| h_rvalid | output | 1 | Response valid, one cycle after the request |
| h_rdata | output | DW | Response read data |
| m_req | output | 1 | Forwarded memory request |
| m_we | output | 1 | Forwarded write enable |
| m_addr | output | AW | Forwarded address |
| m_wdata | output | DW | Forwarded write data |
| m_rdata | input | DW | Memory read data, one cycle after `m_req` |
| eng_busy | input | 1 | Command-list engine running |
| eng_abort | output | 1 | One-cycle abort pulse to the engine |
| nmi | output | 1 | One-cycle non-maskable interrupt pulse |

## Verification
The assertions assume that `eng_busy` changes only at clock edges. They also assume that the engine drops `eng_busy` on the cycle after it sees `eng_abort`, so no single busy period produces a run of back-to-back violations. The bench follows both rules. Its engine model raises busy only on a start command and lowers it on abort or on a stop command. Host requests are single-cycle and are driven away from the clock edge. Memory is a bench model with the one-cycle read latency that the guard expects.

// File: rtl/cag_pkg.sv
// Shared types for the coprocessor access guard.
// Assumes: nothing beyond IEEE 1800-2017.
package cag_pkg;
    // Source of the word returned on the host response path.
    typedef enum logic [1:0] {
        SRC_MEM    = 2'd0,
        SRC_STAT   = 2'd1,
        SRC_POISON = 2'd2
    } rsp_src_e;
endpackage

// File: rtl/cag_decode.sv
// Address classifier: marks accesses inside the always-reachable
// control page and the status word within it.
// Assumes: CTRL_WORDS is a power of two and STAT_IDX < CTRL_WORDS.
module cag_decode #(
    parameter int AW         = 10,
    parameter int CTRL_WORDS = 8,
    parameter int STAT_IDX   = 5
) (
    input  logic [AW-1:0] addr_i,
    output logic          ctrl_hit_o,
    output logic          stat_hit_o
);
    localparam int CW = $clog2(CTRL_WORDS);

    // Control page is the top CTRL_WORDS addresses; status is one word of it.
    always_comb begin
        ctrl_hit_o = &addr_i[AW-1:CW];
        stat_hit_o = ctrl_hit_o && (addr_i[CW-1:0] == CW'(STAT_IDX));
    end
endmodule

// File: rtl/cag_status.sv
// Violation status: sticky error flag with write-one-to-clear, plus
// single-cycle NMI and abort pulses for every violation.
// Assumes: viol_i and clr_i never arrive in the same cycle (one host access per cycle).
module cag_status (
    input  logic clk,
    input  logic rst_n,
    input  logic viol_i,
    input  logic clr_i,
    output logic err_o,
    output logic nmi_o,
    output logic abort_o
);
    logic err_q;
    logic nmi_q;
    logic abort_q;

    // Sticky error flag: set by a violation, cleared by host write-one.
    always_ff @(posedge clk) begin
        if (!rst_n)      err_q <= 1'b0;
        else if (viol_i) err_q <= 1'b1;
        else if (clr_i)  err_q <= 1'b0;
    end

    // One-cycle interrupt and abort pulses, one per violation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_q   <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            nmi_q   <= viol_i;
            abort_q <= viol_i;
        end
    end

    assign err_o   = err_q;
    assign nmi_o   = nmi_q;
    assign abort_o = abort_q;

    // R5
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol_i |=> err_q);
    // R6
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !clr_i) |=> err_q);
    // R7
    nmi_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol_i |=> nmi_q);
    // R8
    abort_with_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_q |-> nmi_q);
endmodule

// File: rtl/cop_access_guard.sv
// Coprocessor memory access guard. Forwards host accesses to local RAM and
// registers while the command-list engine is idle. While it runs, it rejects
// accesses outside the control page, returns poison, and raises NMI and abort.
// Assumes: memory answers one cycle after m_req; eng_busy changes at clock edges.
module cop_access_guard
    import cag_pkg::*;
#(
    parameter int          AW         = 10,
    parameter int          DW         = 32,
    parameter int          CTRL_WORDS = 8,
    parameter int          STAT_IDX   = 5,
    parameter logic [31:0] POISON     = 32'hBAD0_BAD0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          h_req,
    input  logic          h_we,
    input  logic [AW-1:0] h_addr,
    input  logic [DW-1:0] h_wdata,
    output logic          h_rvalid,
    output logic [DW-1:0] h_rdata,
    output logic          m_req,
    output logic          m_we,
    output logic [AW-1:0] m_addr,
    output logic [DW-1:0] m_wdata,
    input  logic [DW-1:0] m_rdata,
    input  logic          eng_busy,
    output logic          eng_abort,
    output logic          nmi
);
    localparam logic [DW-1:0] POISON_W = DW'(POISON);

    logic     ctrl_hit;
    logic     stat_hit;
    logic     viol;
    logic     clr;
    logic     err;
    logic     rvalid_q;
    rsp_src_e src_d;
    rsp_src_e src_q;
    logic [DW-1:0] stat_word;

    cag_decode #(
        .AW(AW), .CTRL_WORDS(CTRL_WORDS), .STAT_IDX(STAT_IDX)
    ) decode_i (
        .addr_i    (h_addr),
        .ctrl_hit_o(ctrl_hit),
        .stat_hit_o(stat_hit)
    );

    cag_status status_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .viol_i (viol),
        .clr_i  (clr),
        .err_o  (err),
        .nmi_o  (nmi),
        .abort_o(eng_abort)
    );

    // Classify the current request and gate the memory-side request.
    always_comb begin
        viol    = h_req && eng_busy && !ctrl_hit;
        clr     = h_req && h_we && stat_hit && h_wdata[0];
        m_req   = h_req && !viol && !stat_hit;
        m_we    = h_we;
        m_addr  = h_addr;
        m_wdata = h_wdata;
        if (viol)          src_d = SRC_POISON;
        else if (stat_hit) src_d = SRC_STAT;
        else               src_d = SRC_MEM;
    end

    // Response stage: valid and data source one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
            src_q    <= SRC_MEM;
        end else begin
            rvalid_q <= h_req;
            src_q    <= src_d;
        end
    end

    // Status word layout: the error flag in bit 0, the other bits zero.
    generate
        if (DW > 1) begin : g_stat_wide
            assign stat_word = {{(DW-1){1'b0}}, err};
        end else begin : g_stat_narrow
            assign stat_word = err;
        end
    endgenerate

    // Select the returned word from the registered source.
    always_comb begin
        case (src_q)
            SRC_POISON: h_rdata = POISON_W;
            SRC_STAT:   h_rdata = stat_word;
            default:    h_rdata = m_rdata;
        endcase
    end

    assign h_rvalid = rvalid_q;

    // R2
    no_fwd_when_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_busy && h_req && !ctrl_hit) |-> !m_req);
    // R4
    ctrl_no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_req && ctrl_hit) |=> !eng_abort);
    // R9
    rvalid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_req |=> h_rvalid);
    // R7
    nmi_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi && !viol) |=> !nmi);
endmodule

// File: tb/cop_access_guard_tb_top.sv
module cop_access_guard_tb_top;
    localparam int          AW     = 10;
    localparam int          DW     = 32;
    localparam logic [31:0] POISON = 32'hBAD0_BAD0;
    localparam logic [9:0]  STAT_A = 10'd1021;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic h_req = 1'b0, h_we = 1'b0;
    logic [AW-1:0] h_addr = '0;
    logic [DW-1:0] h_wdata = '0;
    logic h_rvalid, m_req, m_we, eng_abort, nmi;
    logic [DW-1:0] h_rdata, m_wdata;
    logic [DW-1:0] m_rdata;
    logic [AW-1:0] m_addr;
    logic eng_busy;
    logic start_req = 1'b0, stop_req = 1'b0;
    logic [DW-1:0] mem [1024];
    int n_chk = 0, n_fail = 0;
    logic rv, nm, ab;
    logic [DW-1:0] rd;

    always #5 clk = ~clk;

    cop_access_guard dut_i (
        .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_we(h_we), .h_addr(h_addr),
        .h_wdata(h_wdata), .h_rvalid(h_rvalid), .h_rdata(h_rdata), .m_req(m_req),
        .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata),
        .eng_busy(eng_busy), .eng_abort(eng_abort), .nmi(nmi)
    );

    // Memory model with one-cycle read latency.
    always_ff @(posedge clk) begin
        if (m_req) begin
            if (m_we) mem[m_addr] <= m_wdata;
            m_rdata <= mem[m_addr];
        end
    end

    // Engine model: busy on start, idle on abort or stop.
    always_ff @(posedge clk) begin
        if (!rst_n)         eng_busy <= 1'b0;
        else if (eng_abort) eng_busy <= 1'b0;
        else if (stop_req)  eng_busy <= 1'b0;
        else if (start_req) eng_busy <= 1'b1;
    end

    typedef struct packed {
        logic        busy;
        logic        we;
        logic [9:0]  addr;
        logic [31:0] wd;
        logic        chk_rd;
        logic [31:0] exp;
        logic        exp_nmi;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 10'd10,   32'h0000_00A1, 1'b0, 32'h0,          1'b0}, // R1
        '{1'b0, 1'b1, 10'd20,   32'h0000_00B2, 1'b0, 32'h0,          1'b0}, // R1
        '{1'b0, 1'b0, 10'd10,   32'h0,         1'b1, 32'h0000_00A1,  1'b0}, // R1
        '{1'b1, 1'b0, 10'd20,   32'h0,         1'b1, 32'hBAD0_BAD0,  1'b1}, // R2
        '{1'b1, 1'b1, 10'd10,   32'h0000_00FF, 1'b0, 32'h0,          1'b1}, // R3
        '{1'b0, 1'b0, 10'd10,   32'h0,         1'b1, 32'h0000_00A1,  1'b0}, // R3
        '{1'b1, 1'b1, 10'd1016, 32'h0000_0055, 1'b0, 32'h0,          1'b0}, // R4
        '{1'b1, 1'b0, 10'd1016, 32'h0,         1'b1, 32'h0000_0055,  1'b0}, // R4
        '{1'b0, 1'b0, 10'd20,   32'h0,         1'b1, 32'h0000_00B2,  1'b0}  // R1
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_busy(input logic b);
        @(negedge clk);
        if (b && !eng_busy) start_req = 1'b1;
        if (!b && eng_busy) stop_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        stop_req = 1'b0;
    endtask

    // One host access; outputs sampled 1 ns after the response edge.
    task automatic access(input logic we, input logic [9:0] a, input logic [31:0] wd,
                          output logic o_rv, output logic [31:0] o_rd,
                          output logic o_nm, output logic o_ab);
        @(negedge clk);
        h_req = 1'b1; h_we = we; h_addr = a; h_wdata = wd;
        @(posedge clk);
        #1;
        o_rv = h_rvalid; o_rd = h_rdata; o_nm = nmi; o_ab = eng_abort;
        @(negedge clk);
        h_req = 1'b0; h_we = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10 reset state
        check("R10 rvalid", 32'(h_rvalid), 32'd0);
        check("R10 nmi", 32'(nmi), 32'd0);
        check("R10 abort", 32'(eng_abort), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        access(1'b0, STAT_A, 32'h0, rv, rd, nm, ab);
        check("R10 err flag", rd, 32'd0);

        for (int i = 0; i < NV; i++) begin
            set_busy(VECS[i].busy);
            access(VECS[i].we, VECS[i].addr, VECS[i].wd, rv, rd, nm, ab);
            check($sformatf("R9 rvalid v%0d", i), 32'(rv), 32'd1);
            if (VECS[i].chk_rd)
                check($sformatf("R1-path rdata v%0d", i), rd, VECS[i].exp);
            check($sformatf("R7 nmi v%0d", i), 32'(nm), 32'(VECS[i].exp_nmi));
            check($sformatf("R8 abort v%0d", i), 32'(ab), 32'(VECS[i].exp_nmi));
            @(posedge clk);
            #1;
            check($sformatf("R7 nmi width v%0d", i), 32'(nmi), 32'd0);
            check($sformatf("R8 abort width v%0d", i), 32'(eng_abort), 32'd0);
            check($sformatf("R9 rvalid idle v%0d", i), 32'(h_rvalid), 32'd0);
        end
        set_busy(1'b0);

        // R5: flag set by earlier violations; readable via status word
        access(1'b0, STAT_A, 32'h0, rv, rd, nm, ab);
        check("R5 err set", rd, 32'd1);
        // R6: write 0 leaves flag; write 1 clears
        access(1'b1, STAT_A, 32'h0, rv, rd, nm, ab);
        access(1'b0, STAT_A, 32'h0, rv, rd, nm, ab);
        check("R6 write0 keeps", rd, 32'd1);
        access(1'b1, STAT_A, 32'h1, rv, rd, nm, ab);
        access(1'b0, STAT_A, 32'h0, rv, rd, nm, ab);
        check("R6 write1 clears", rd, 32'd0);
        // R4: status readable while busy without violation
        set_busy(1'b1);
        access(1'b0, STAT_A, 32'h0, rv, rd, nm, ab);
        check("R4 status busy rd", rd, 32'd0);
        check("R4 status busy nmi", 32'(nm), 32'd0);
        // R5: flag set one cycle after a blocked access at top of RAM area
        access(1'b0, 10'd1015, 32'h0, rv, rd, nm, ab);
        check("R2 poison edge", rd, POISON);
        check("R5 nmi edge", 32'(nm), 32'd1);
        access(1'b0, STAT_A, 32'h0, rv, rd, nm, ab);
        check("R5 err after edge", rd, 32'd1);
        set_busy(1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule